// File: doc/BRIEF.md
# Quota-Aware Set Replacement Controller

This block performs lookup and replacement for one set of a set-associative cache shared by several cores. Each request carries a tag, the ID of the issuing core, and a valid flag. The block compares the tag against every way of the set at once and reports a hit, or on a miss a victim way. It then fills that victim with the new tag, the requesting core as its owner, and a set valid bit. Data storage, multiple sets and the path to the next memory level are outside this block. A single set of tag, owner and valid registers stands in for an indexed array.

Replacement enforces a programmable limit on how many ways of the set each core may hold. The limit is a count, not a fixed group of columns, so a core's blocks may occupy any physical way. Recency is tracked as a full ordering of the ways. Every hit or fill moves the touched way to the most recently used position in the same clock edge. The victim is always taken as the least recent member of the candidate group that the quota rule picks.

Top module: `way_quota_set`

## Requirements
- R1: After a synchronous active-high reset, every way is invalid, resp_valid_o is low, and recency runs from way 0 (most recent) to way WAYS-1 (least recent), so the first miss fills way WAYS-1.
- R2: A request sampled at a clock edge produces exactly one response, registered at that edge. In a cycle without a request, resp_valid_o is low after the edge.
- R3: A request hits when a valid way holds an equal tag. The response then has resp_hit_o=1 and resp_way_o set to that way, with resp_src_o=0 and resp_evict_o=0.
- R4: The accessed way (hit way or filled victim) becomes most recent. Ways that were more recent than it age by one position, and older ways keep their positions.
- R5: On a miss, the victim way takes the request tag, the requesting core as owner, and becomes valid, so a repeat of the same tag hits that way.
- R6: If any way is invalid, a miss picks the least recent invalid way and reports resp_src_o=0, whatever the quotas.
- R7: With no invalid way, a requester holding fewer valid ways than its quota takes the least recent way owned by another core whose holdings exceed that core's quota, and reports resp_src_o=1. Core c's quota is quota_i[c*QW +: QW] with QW=$clog2(WAYS+1), read in the cycle of the request.
- R8: With no invalid way, a requester holding at least its quota replaces its own least recent way and reports resp_src_o=2.
- R9: When the rule of R7 or R8 finds no candidate, the globally least recent way is replaced and resp_src_o=3.
- R10: A hit by a core that does not own the way leaves the owner, and so every core's holdings, unchanged.
- R11: resp_evict_o is 1 exactly when a miss replaced a way that was valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_tag_i | input | TAG_W | Request tag |
| req_core_i | input | CID_W | Issuing core ID |
| quota_i | input | NUM_CORES*QW | Per-core way quotas, core 0 in the low bits |
| resp_valid_o | output | 1 | Response valid |
| resp_hit_o | output | 1 | Request hit |
| resp_way_o | output | WAY_W | Hit way or filled victim way |
| resp_evict_o | output | 1 | Miss replaced a valid block |
| resp_src_o | output | 2 | Victim class: 0 free, 1 reclaimed, 2 own, 3 fallback |

## Verification
The bench builds the block with four ways, three cores and 8-bit tags. It draws tags from a pool of twelve, so hits, misses, full sets and repeated evictions all occur often. Having three cores lets more than one other core be over quota at the same time. Giving one core a quota of zero makes the own-block rule come up empty. Quotas are also reprogrammed to sums above and below the way count, which makes the reclaim case and the fallback case both reachable, alongside a directed sequence for ownership after cross-core hits.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {
    SRC_FREE    = 2'd0,
    SRC_RECLAIM = 2'd1,
    SRC_SELF    = 2'd2,
    SRC_ANY     = 2'd3
  } victim_src_e;
endpackage

// File: rtl/wq_tag_match.sv
module wq_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wq_recency.sv
module wq_recency #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       touch_i,
  input  logic [WAY_W-1:0]           touch_way_i,
  output logic [WAYS-1:0][WAY_W-1:0] rank_o
);
  logic [WAYS-1:0][WAY_W-1:0] rank_q;
  logic [WAY_W-1:0]           touched_rank;

  assign touched_rank = rank_q[touch_way_i];
  assign rank_o       = rank_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          rank_q[w] <= '0;
        else if (rank_q[w] < touched_rank)
          rank_q[w] <= rank_q[w] + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/wq_victim_sel.sv
module wq_victim_sel
  import wq_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int NUM_CORES = 4,
  parameter int CID_W     = 2,
  parameter int QW        = 3,
  parameter int WAY_W     = 2
) (
  input  logic [WAYS-1:0]                valid_i,
  input  logic [WAYS-1:0][CID_W-1:0]     owner_i,
  input  logic [WAYS-1:0][WAY_W-1:0]     rank_i,
  input  logic [NUM_CORES-1:0][QW-1:0]   quota_i,
  input  logic [CID_W-1:0]               req_core_i,
  output logic [WAY_W-1:0]               victim_way_o,
  output victim_src_e                    victim_src_o
);
  logic [NUM_CORES-1:0][QW-1:0] occ;
  logic [QW-1:0]                req_quota;
  logic [QW-1:0]                req_occ;
  logic [WAYS-1:0]              free_m;
  logic [WAYS-1:0]              over_m;
  logic [WAYS-1:0]              own_m;
  logic [WAY_W:0]               pick_free;
  logic [WAY_W:0]               pick_over;
  logic [WAY_W:0]               pick_own;
  logic [WAY_W:0]               pick_any;

  function automatic logic [WAY_W:0] oldest(
    input logic [WAYS-1:0]            m,
    input logic [WAYS-1:0][WAY_W-1:0] r
  );
    logic             found;
    logic [WAY_W-1:0] best;
    logic [WAY_W-1:0] best_r;
    found  = 1'b0;
    best   = '0;
    best_r = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m[w] && (!found || r[w] > best_r)) begin
        found  = 1'b1;
        best   = WAY_W'(w);
        best_r = r[w];
      end
    end
    return {found, best};
  endfunction

  always_comb begin
    occ = '0;
    for (int w = 0; w < WAYS; w++) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (valid_i[w] && owner_i[w] == CID_W'(c)) occ[c] = occ[c] + QW'(1);
      end
    end
    req_quota = '0;
    req_occ   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (req_core_i == CID_W'(c)) begin
        req_quota = quota_i[c];
        req_occ   = occ[c];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      free_m[w] = !valid_i[w];
      own_m[w]  = valid_i[w] && (owner_i[w] == req_core_i);
      over_m[w] = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (valid_i[w] && owner_i[w] == CID_W'(c) && owner_i[w] != req_core_i &&
            occ[c] > quota_i[c])
          over_m[w] = 1'b1;
      end
    end
  end

  assign pick_free = oldest(free_m, rank_i);
  assign pick_over = oldest(over_m, rank_i);
  assign pick_own  = oldest(own_m, rank_i);
  assign pick_any  = oldest({WAYS{1'b1}}, rank_i);

  always_comb begin
    victim_way_o = pick_any[WAY_W-1:0];
    victim_src_o = SRC_ANY;
    if (pick_free[WAY_W]) begin
      victim_way_o = pick_free[WAY_W-1:0];
      victim_src_o = SRC_FREE;
    end else if (req_occ < req_quota) begin
      if (pick_over[WAY_W]) begin
        victim_way_o = pick_over[WAY_W-1:0];
        victim_src_o = SRC_RECLAIM;
      end
    end else if (pick_own[WAY_W]) begin
      victim_way_o = pick_own[WAY_W-1:0];
      victim_src_o = SRC_SELF;
    end
  end
endmodule

// File: rtl/way_quota_set.sv
module way_quota_set
  import wq_pkg::*;
#(
  parameter int  WAYS      = 4,
  parameter int  TAG_W     = 20,
  parameter int  NUM_CORES = 4,
  localparam int CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int QW        = $clog2(WAYS + 1),
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      req_valid_i,
  input  logic [TAG_W-1:0]          req_tag_i,
  input  logic [CID_W-1:0]          req_core_i,
  input  logic [NUM_CORES*QW-1:0]   quota_i,
  output logic                      resp_valid_o,
  output logic                      resp_hit_o,
  output logic [WAY_W-1:0]          resp_way_o,
  output logic                      resp_evict_o,
  output logic [1:0]                resp_src_o
);
  logic [WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [WAYS-1:0][CID_W-1:0]   owner_q;
  logic [WAYS-1:0]              valid_q;
  logic [WAYS-1:0][WAY_W-1:0]   way_rank;
  logic [NUM_CORES-1:0][QW-1:0] quota_arr;
  logic [WAYS-1:0]              hit_vec;
  logic [WAY_W-1:0]             hit_way;
  logic                         hit;
  logic [WAY_W-1:0]             victim_way;
  victim_src_e                  victim_src;
  logic [WAY_W-1:0]             access_way;
  logic                         fill;
  victim_src_e                  resp_src_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_quota
    assign quota_arr[c] = quota_i[c*QW +: QW];
  end

  wq_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .tags_i   (tag_q),
    .valid_i  (valid_q),
    .tag_i    (req_tag_i),
    .hit_vec_o(hit_vec),
    .hit_way_o(hit_way)
  );

  wq_victim_sel #(
    .WAYS(WAYS), .NUM_CORES(NUM_CORES), .CID_W(CID_W), .QW(QW), .WAY_W(WAY_W)
  ) u_victim (
    .valid_i     (valid_q),
    .owner_i     (owner_q),
    .rank_i      (way_rank),
    .quota_i     (quota_arr),
    .req_core_i  (req_core_i),
    .victim_way_o(victim_way),
    .victim_src_o(victim_src)
  );

  assign hit        = |hit_vec;
  assign fill       = req_valid_i && !hit;
  assign access_way = hit ? hit_way : victim_way;

  wq_recency #(.WAYS(WAYS), .WAY_W(WAY_W)) u_recency (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .touch_i    (req_valid_i),
    .touch_way_i(access_way),
    .rank_o     (way_rank)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tag_q   <= '0;
      owner_q <= '0;
      valid_q <= '0;
    end else if (fill) begin
      tag_q[victim_way]   <= req_tag_i;
      owner_q[victim_way] <= req_core_i;
      valid_q[victim_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_way_o   <= '0;
      resp_evict_o <= 1'b0;
      resp_src_q   <= SRC_FREE;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        resp_hit_o   <= hit;
        resp_way_o   <= access_way;
        resp_evict_o <= fill && valid_q[victim_way];
        resp_src_q   <= hit ? SRC_FREE : victim_src;
      end
    end
  end

  assign resp_src_o = resp_src_q;
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
  parameter int WAYS  = 4,
  parameter int CID_W = 2,
  parameter int WAY_W = 2
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic                       req_valid_i,
  input logic [CID_W-1:0]           req_core_i,
  input logic                       resp_valid_o,
  input logic                       resp_hit_o,
  input logic [WAY_W-1:0]           resp_way_o,
  input logic                       resp_evict_o,
  input logic [1:0]                 resp_src_o,
  input logic [WAYS-1:0]            valid_q,
  input logic [WAYS-1:0][CID_W-1:0] owner_q,
  input logic [WAYS-1:0][WAY_W-1:0] way_rank,
  input logic [WAYS-1:0]            hit_vec
);
  logic [WAYS-1:0] prev_valid;
  always_ff @(posedge clk_i) prev_valid <= valid_q;

  a_r2_resp_follows_req: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i |=> resp_valid_o);

  a_r2_no_spurious_resp: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_valid_i |=> !resp_valid_o);

  a_r3_single_match: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(hit_vec));

  a_r4_access_is_mru: assert property (@(posedge clk_i) disable iff (rst_i)
    resp_valid_o |-> (way_rank[resp_way_o] == '0));

  a_r5_fill_owner: assert property (@(posedge clk_i) disable iff (rst_i)
    (resp_valid_o && !resp_hit_o) |->
      (valid_q[resp_way_o] && owner_q[resp_way_o] == $past(req_core_i)));

  a_r6_free_was_invalid: assert property (@(posedge clk_i) disable iff (rst_i)
    (resp_valid_o && !resp_hit_o && resp_src_o == 2'd0) |-> !prev_valid[resp_way_o]);

  a_r11_evict_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    (resp_valid_o && !resp_hit_o) |-> (resp_evict_o == prev_valid[resp_way_o]));

  for (genvar r = 0; r < WAYS; r++) begin : g_perm
    logic [WAYS-1:0] at_r;
    always_comb begin
      for (int w = 0; w < WAYS; w++) at_r[w] = (way_rank[w] == WAY_W'(r));
    end
    a_r4_rank_permutation: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot(at_r));
  end
endmodule

bind way_quota_set wq_checker #(.WAYS(WAYS), .CID_W(CID_W), .WAY_W(WAY_W)) u_wq_checker (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .req_valid_i (req_valid_i),
  .req_core_i  (req_core_i),
  .resp_valid_o(resp_valid_o),
  .resp_hit_o  (resp_hit_o),
  .resp_way_o  (resp_way_o),
  .resp_evict_o(resp_evict_o),
  .resp_src_o  (resp_src_o),
  .valid_q     (valid_q),
  .owner_q     (owner_q),
  .way_rank    (way_rank),
  .hit_vec     (hit_vec)
);

// File: tb/way_quota_set_bench.sv
`timescale 1ns/1ps
module way_quota_set_bench;
  localparam int WAYS      = 4;
  localparam int TAG_W     = 8;
  localparam int NUM_CORES = 3;
  localparam int CID_W     = 2;
  localparam int QW        = 3;
  localparam int WAY_W     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                    req_valid = 1'b0;
  logic [TAG_W-1:0]        req_tag = '0;
  logic [CID_W-1:0]        req_core = '0;
  logic [NUM_CORES*QW-1:0] quota = '0;
  logic                    resp_valid;
  logic                    resp_hit;
  logic [WAY_W-1:0]        resp_way;
  logic                    resp_evict;
  logic [1:0]              resp_src;

  way_quota_set #(.WAYS(WAYS), .TAG_W(TAG_W), .NUM_CORES(NUM_CORES)) u_way_quota_set (
    .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_tag_i(req_tag),
    .req_core_i(req_core), .quota_i(quota), .resp_valid_o(resp_valid),
    .resp_hit_o(resp_hit), .resp_way_o(resp_way), .resp_evict_o(resp_evict),
    .resp_src_o(resp_src)
  );

  int n_run = 0;
  int n_fail = 0;

  // behavioural model: recency as a list, most recent first
  int m_order[$];
  bit m_valid[WAYS];
  int m_tag[WAYS];
  int m_own[WAYS];
  int m_quota[NUM_CORES];
  bit e_valid, e_hit, e_evict;
  int e_way, e_src;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_quota(input int q0, input int q1, input int q2);
    m_quota[0] = q0; m_quota[1] = q1; m_quota[2] = q2;
    quota = {QW'(q2), QW'(q1), QW'(q0)};
  endtask

  function automatic void model_reset();
    m_order = {};
    for (int w = 0; w < WAYS; w++) begin
      m_order.push_back(w);
      m_valid[w] = 1'b0;
      m_tag[w] = 0;
      m_own[w] = 0;
    end
  endfunction

  function automatic void model_access(input int tag, input int core);
    int v;
    int w;
    int occ[NUM_CORES];
    v = -1;
    for (int i = 0; i < WAYS; i++) if (m_valid[i] && m_tag[i] == tag) v = i;
    if (v >= 0) begin
      e_hit = 1; e_way = v; e_evict = 0; e_src = 0;
    end else begin
      e_hit = 0;
      for (int i = WAYS - 1; i >= 0; i--) if (v < 0 && !m_valid[m_order[i]]) v = m_order[i];
      if (v >= 0) e_src = 0;
      else begin
        for (int c = 0; c < NUM_CORES; c++) occ[c] = 0;
        for (int i = 0; i < WAYS; i++) occ[m_own[i]]++;
        if (occ[core] < m_quota[core]) begin
          for (int i = WAYS - 1; i >= 0; i--) begin
            w = m_order[i];
            if (v < 0 && m_own[w] != core && occ[m_own[w]] > m_quota[m_own[w]]) v = w;
          end
          e_src = 1;
        end else begin
          for (int i = WAYS - 1; i >= 0; i--) begin
            w = m_order[i];
            if (v < 0 && m_own[w] == core) v = w;
          end
          e_src = 2;
        end
        if (v < 0) begin v = m_order[WAYS-1]; e_src = 3; end
      end
      e_way = v;
      e_evict = m_valid[v];
      m_valid[v] = 1; m_tag[v] = tag; m_own[v] = core;
    end
    for (int i = 0; i < m_order.size(); i++) begin
      if (m_order[i] == e_way) begin m_order.delete(i); break; end
    end
    m_order.push_front(e_way);
  endfunction

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic step(input bit v, input int tag, input int core);
    string t;
    req_valid = v; req_tag = TAG_W'(tag); req_core = CID_W'(core);
    e_valid = v;
    if (v) model_access(tag, core);
    @(negedge clk);
    check("R2", int'(resp_valid), int'(e_valid));
    if (e_valid) begin
      case (e_src)
        0: t = "R4 R6";
        1: t = "R4 R7";
        2: t = "R4 R8";
        default: t = "R4 R9";
      endcase
      if (e_hit) t = "R3 R5";
      check("R3", int'(resp_hit), int'(e_hit));
      check(t, int'(resp_way), e_way);
      check("R11", int'(resp_evict), int'(e_evict));
      check(t, int'(resp_src), e_src);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1", int'(resp_valid), 0);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    set_quota(1, 3, 0);
    do_reset();
    step(0, 0, 0);
    // first miss after reset lands in the last way
    step(1, 'h10, 0);
    check("R1", int'(resp_way), WAYS - 1);
    step(1, 'h10, 0);
    check("R5", int'(resp_hit), 1);
    step(1, 'h20, 1);
    step(1, 'h21, 1);
    step(1, 'h22, 1);
    step(1, 'h23, 1);          // own replacement for core 1
    check("R8", int'(resp_src), 2);
    step(1, 'h11, 0);          // own replacement for core 0
    set_quota(3, 1, 0);
    step(1, 'h12, 0);          // reclaim from over-quota core 1
    check("R7", int'(resp_src), 1);
    step(1, 'h50, 2);          // quota zero, owns nothing: fallback
    check("R9", int'(resp_src), 3);
    step(0, 0, 0);

    // ownership kept across a hit by another core
    set_quota(2, 2, 0);
    do_reset();
    step(1, 'h30, 1);
    step(1, 'h31, 1);
    step(1, 'h32, 0);
    step(1, 'h33, 0);
    step(1, 'h30, 0);          // core 0 hits core 1's block in way 3
    check("R10", int'(resp_way), 3);
    step(1, 'h34, 1);          // core 1 still at quota: own LRU is way 2
    check("R10", int'(resp_src), 2);
    check("R10", int'(resp_way), 2);

    // random traffic with reprogrammed quotas
    for (int n = 0; n < 3000; n++) begin
      if (n % 100 == 0) begin
        int a, b;
        if ($urandom_range(0, 1) == 0) begin
          a = $urandom_range(0, 4);
          b = $urandom_range(0, 4 - a);
          set_quota(a, b, 4 - a - b);
        end else begin
          set_quota($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4));
        end
      end
      step($urandom_range(0, 9) < 8, 'h40 + $urandom_range(0, 11), $urandom_range(0, 2));
    end
    step(0, 0, 0);
    summary();
    $finish;
  end
endmodule